// File: doc/BRIEF.md
# Video Raster Timing Generator

The generator tracks the horizontal and vertical position of a video raster. Its only time base is a stream of CPU-cycle counts. Each update adds eleven times the incoming count to a small fractional accumulator. Division by seven turns that sum into whole video cycles, and the remainder is kept for the next update. The video cycles advance a dot position along the current line. When the position passes the end of the line, it wraps, the line counter steps on, and a one-cycle horizontal-blank pulse is issued.

Alongside the position, the block reports how many pixel clocks elapsed during the update, using a divider chosen by the horizontal resolution setting. It also keeps a vertical-blank level that starts at line 240 and ends when the frame wraps. A single-cycle interrupt marks the start of vertical blank. The block also keeps an odd/even field bit, which toggles on a rule set by the interlace and vertical-resolution settings. A surrounding video unit calls it once per CPU step and uses the results to pace display fetch and timers.

Top module: `raster_timing_gen`

## Requirements
- R1: An update (`step_valid`=1) adds 11×`step_cycles` to the stored remainder. It advances the dot position by the sum divided by 7, and keeps the sum modulo 7 for the next update. `step_cycles` never exceeds `MAX_STEP` (2166), so an update advances less than one line.
- R2: A line is 3413 video cycles long when `pal_mode`=0 and 3406 when `pal_mode`=1. When the advanced position reaches the line length, the line length is subtracted from it.
- R3: A frame holds 263 lines when `pal_mode`=0 and 314 when `pal_mode`=1. A line increment that reaches the frame length returns the line counter to 0.
- R4: The pixel divider is 7 when `hres_wide`=1. Otherwise `hres_sel` values 0, 1, 2 and 3 select dividers 10, 8, 5 and 4.
- R5: `dot_clocks` equals the advance divided by the divider, plus one when (new position before wrap) mod divider is less than the advance mod divider. It is visible in the cycle after the update.
- R6: `hblank` is high for exactly the one cycle after an update whose position wrapped.
- R7: `vblank` goes high, and `vblank_irq` pulses for one cycle, in the cycle after an update that brings the line counter to 240. `vblank` drops in the cycle after the frame wraps to line 0.
- R8: The tall (480-line) field mode applies only when both `vres_hi` and `interlace` are 1. With `interlace`=0 the field bit never toggles.
- R9: With `interlace`=1 in 240-line mode, the field bit toggles on every line increment whose new value is below 240. In 480-line mode, it toggles only when the frame wraps.
- R10: `odd_field` shows the field bit forced to 0 while `vblank` is high.
- R11: Reset clears the remainder, position, line, field bit and flags. All outputs read 0.
- R12: A cycle without an update changes no state. `dot_clocks` reads 0 in the following cycle, and `hblank` and `vblank_irq` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Update strobe for this cycle |
| step_cycles | input | CYC_W (12) | CPU cycles in this update |
| pal_mode | input | 1 | 0 selects the 525-line timing, 1 the 625-line timing |
| hres_wide | input | 1 | Selects the divide-by-7 pixel rate |
| hres_sel | input | 2 | Pixel divider select when hres_wide is 0 |
| vres_hi | input | 1 | Requests 480-line vertical resolution |
| interlace | input | 1 | Interlaced scan enable |
| dot_clocks | output | DOT_W (13) | Pixel clocks elapsed in the last update |
| hblank | output | 1 | One-cycle line wrap pulse |
| vblank | output | 1 | Vertical blank level |
| vblank_irq | output | 1 | One-cycle vertical blank interrupt |
| odd_field | output | 1 | Field bit, masked during vertical blank |

## Verification
The assertions check, on every cycle, the properties that need no arithmetic:

- the interrupt is one cycle wide and lines up with the rising edge of vertical blank;
- vertical blank falls only together with a line wrap;
- idle cycles produce no pulses and no pixel count;
- the field output is masked during blank;
- the per-update input stays within its limit.

The dot arithmetic cannot be checked that way. The fractional remainder, the divider choice, the extra-dot rule, the two line and frame lengths, and the two interlace toggle rules can only be shown by the bench's scenarios, which compare each cycle against a behavioural model while the modes are swept. Frame-level counts of line pulses between interrupts confirm the frame lengths.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int RT_DOT_W  = 13;
    localparam int RT_LINE_W = 9;
    localparam int RT_REM_W  = 3;
    localparam int RT_NDIV   = 5;

    // Pixel divider for each selector slot; slot 4 is the wide mode.
    function automatic int rt_div_of(input int idx);
        case (idx)
            0:       return 10;
            1:       return 8;
            2:       return 5;
            3:       return 4;
            default: return 7;
        endcase
    endfunction

    typedef struct packed {
        logic [RT_REM_W-1:0]  rem;
        logic [RT_DOT_W-1:0]  dot;
        logic [RT_LINE_W-1:0] line;
        logic                 odd;
        logic                 vbl;
        logic [RT_DOT_W-1:0]  dots_out;
        logic                 hbl;
        logic                 irq;
    } rt_state_t;

endpackage

// File: rtl/rt_cycle_conv.sv
module rt_cycle_conv #(
    parameter int CYC_W = 12,
    parameter int DOT_W = 13,
    parameter int REM_W = 3,
    parameter int MUL   = 11,
    parameter int DEN   = 7
) (
    input  logic [REM_W-1:0] rem_q,
    input  logic [CYC_W-1:0] cycles,
    output logic [DOT_W-1:0] advance,
    output logic [REM_W-1:0] rem_d
);
    localparam int SUM_W = CYC_W + $clog2(MUL) + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] quo;
    logic [SUM_W-1:0] md;

    always_comb begin
        sum     = SUM_W'(rem_q) + SUM_W'(cycles) * SUM_W'(MUL);
        quo     = sum / SUM_W'(DEN);
        md      = sum % SUM_W'(DEN);
        advance = DOT_W'(quo);
        rem_d   = REM_W'(md);
    end
endmodule

// File: rtl/rt_dot_divider.sv
module rt_dot_divider
    import raster_pkg::*;
#(
    parameter int DOT_W = 13
) (
    input  logic [DOT_W-1:0] pos_new,
    input  logic [DOT_W-1:0] advance,
    input  logic             hres_wide,
    input  logic [1:0]       hres_sel,
    output logic [DOT_W-1:0] dots
);
    logic [DOT_W-1:0] cnt [RT_NDIV];

    for (genvar g = 0; g < RT_NDIV; g++) begin : g_div
        localparam int D = rt_div_of(g);
        logic [DOT_W-1:0] q;
        logic [DOT_W-1:0] rp;
        logic [DOT_W-1:0] ra;
        always_comb begin
            q      = advance / DOT_W'(D);
            rp     = pos_new % DOT_W'(D);
            ra     = advance % DOT_W'(D);
            cnt[g] = q + DOT_W'(rp < ra);
        end
    end

    always_comb begin
        if (hres_wide) begin
            dots = cnt[4];
        end else begin
            case (hres_sel)
                2'd0:    dots = cnt[0];
                2'd1:    dots = cnt[1];
                2'd2:    dots = cnt[2];
                default: dots = cnt[3];
            endcase
        end
    end
endmodule

// File: rtl/rt_line_step.sv
module rt_line_step #(
    parameter int LINE_W     = 9,
    parameter int NTSC_LINES = 263,
    parameter int PAL_LINES  = 314,
    parameter int VBL_LINE   = 240
) (
    input  logic              wrap,
    input  logic [LINE_W-1:0] line_q,
    input  logic              odd_q,
    input  logic              vbl_q,
    input  logic              pal_mode,
    input  logic              interlace,
    input  logic              vres_hi,
    output logic [LINE_W-1:0] line_d,
    output logic              odd_d,
    output logic              vbl_d,
    output logic              irq_d
);
    localparam int INC_W = LINE_W + 1;

    logic [INC_W-1:0] inc;
    logic [INC_W-1:0] frame_len;
    logic             tall;

    always_comb begin
        line_d    = line_q;
        odd_d     = odd_q;
        vbl_d     = vbl_q;
        irq_d     = 1'b0;
        inc       = INC_W'(line_q) + INC_W'(1);
        frame_len = pal_mode ? INC_W'(PAL_LINES) : INC_W'(NTSC_LINES);
        tall      = vres_hi & interlace;
        if (wrap) begin
            if (interlace && !tall && inc < INC_W'(VBL_LINE)) begin
                odd_d = ~odd_q;
            end
            if (inc >= frame_len) begin
                line_d = '0;
                vbl_d  = 1'b0;
                if (tall) begin
                    odd_d = ~odd_q;
                end
            end else begin
                line_d = LINE_W'(inc);
            end
            if (line_d == LINE_W'(VBL_LINE)) begin
                vbl_d = 1'b1;
                irq_d = 1'b1;
            end
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int CYC_W      = 12,
    parameter int DOT_W      = RT_DOT_W,
    parameter int MAX_STEP   = 2166,
    parameter int NTSC_DOTS  = 3413,
    parameter int PAL_DOTS   = 3406,
    parameter int NTSC_LINES = 263,
    parameter int PAL_LINES  = 314,
    parameter int VBL_LINE   = 240
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_valid,
    input  logic [CYC_W-1:0] step_cycles,
    input  logic             pal_mode,
    input  logic             hres_wide,
    input  logic [1:0]       hres_sel,
    input  logic             vres_hi,
    input  logic             interlace,
    output logic [DOT_W-1:0] dot_clocks,
    output logic             hblank,
    output logic             vblank,
    output logic             vblank_irq,
    output logic             odd_field
);
    localparam int LINE_W = RT_LINE_W;
    localparam int REM_W  = RT_REM_W;

    rt_state_t st_q;
    rt_state_t st_d;

    logic [DOT_W-1:0]  advance;
    logic [REM_W-1:0]  rem_d;
    logic [DOT_W-1:0]  pos_sum;
    logic [DOT_W-1:0]  line_len;
    logic              wrap;
    logic [DOT_W-1:0]  dots;
    logic [LINE_W-1:0] line_d;
    logic              odd_d;
    logic              vbl_d;
    logic              irq_d;

    rt_cycle_conv #(
        .CYC_W(CYC_W), .DOT_W(DOT_W), .REM_W(REM_W), .MUL(11), .DEN(7)
    ) u_conv (
        .rem_q   (st_q.rem),
        .cycles  (step_cycles),
        .advance (advance),
        .rem_d   (rem_d)
    );

    always_comb begin
        pos_sum  = st_q.dot + advance;
        line_len = pal_mode ? DOT_W'(PAL_DOTS) : DOT_W'(NTSC_DOTS);
        wrap     = step_valid && (pos_sum >= line_len);
    end

    rt_dot_divider #(.DOT_W(DOT_W)) u_div (
        .pos_new   (pos_sum),
        .advance   (advance),
        .hres_wide (hres_wide),
        .hres_sel  (hres_sel),
        .dots      (dots)
    );

    rt_line_step #(
        .LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES),
        .PAL_LINES(PAL_LINES), .VBL_LINE(VBL_LINE)
    ) u_line (
        .wrap      (wrap),
        .line_q    (st_q.line),
        .odd_q     (st_q.odd),
        .vbl_q     (st_q.vbl),
        .pal_mode  (pal_mode),
        .interlace (interlace),
        .vres_hi   (vres_hi),
        .line_d    (line_d),
        .odd_d     (odd_d),
        .vbl_d     (vbl_d),
        .irq_d     (irq_d)
    );

    always_comb begin
        st_d          = st_q;
        st_d.dots_out = '0;
        st_d.hbl      = 1'b0;
        st_d.irq      = 1'b0;
        if (step_valid) begin
            st_d.rem      = rem_d;
            st_d.dot      = wrap ? (pos_sum - line_len) : pos_sum;
            st_d.dots_out = dots;
            st_d.hbl      = wrap;
            st_d.line     = line_d;
            st_d.odd      = odd_d;
            st_d.vbl      = vbl_d;
            st_d.irq      = irq_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dot_clocks = st_q.dots_out;
    assign hblank     = st_q.hbl;
    assign vblank     = st_q.vbl;
    assign vblank_irq = st_q.irq;
    assign odd_field  = st_q.odd & ~st_q.vbl;

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int CYC_W    = 12,
    parameter int DOT_W    = 13,
    parameter int MAX_STEP = 2166
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_valid,
    input logic [CYC_W-1:0] step_cycles,
    input logic [DOT_W-1:0] dot_clocks,
    input logic             hblank,
    input logic             vblank,
    input logic             vblank_irq,
    input logic             odd_field
);
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (int'(step_cycles) <= MAX_STEP)); // R1

    AST_HBLANK_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |-> $past(step_valid)); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq); // R7

    AST_IRQ_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> vblank); // R7

    AST_BLANK_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> vblank_irq); // R7

    AST_BLANK_FALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> hblank); // R7

    AST_FIELD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> !odd_field); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_valid) |-> (dot_clocks == '0 && !hblank && !vblank_irq)); // R12
endmodule

bind raster_timing_gen rt_checker #(
    .CYC_W(CYC_W), .DOT_W(DOT_W), .MAX_STEP(MAX_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_valid  (step_valid),
    .step_cycles (step_cycles),
    .dot_clocks  (dot_clocks),
    .hblank      (hblank),
    .vblank      (vblank),
    .vblank_irq  (vblank_irq),
    .odd_field   (odd_field)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_W      = 12;
    localparam int DOT_W      = 13;
    localparam int MAX_STEP   = 2166;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_valid = 1'b0;
    logic [CYC_W-1:0] step_cycles = '0;
    logic             pal_mode = 1'b0;
    logic             hres_wide = 1'b0;
    logic [1:0]       hres_sel = 2'd0;
    logic             vres_hi = 1'b0;
    logic             interlace = 1'b0;
    logic [DOT_W-1:0] dot_clocks;
    logic             hblank;
    logic             vblank;
    logic             vblank_irq;
    logic             odd_field;

    raster_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_cycles(step_cycles),
        .pal_mode(pal_mode), .hres_wide(hres_wide), .hres_sel(hres_sel),
        .vres_hi(vres_hi), .interlace(interlace), .dot_clocks(dot_clocks),
        .hblank(hblank), .vblank(vblank), .vblank_irq(vblank_irq), .odd_field(odd_field)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    string phase = "R11";

    // behavioural reference
    int m_acc, m_dot, m_line, m_odd, m_vbl;
    int e_dc, e_hb, e_irq;
    int hb_count, irq_seen, frame_lines;
    int odd_ever;

    task automatic model_reset();
        m_acc = 0; m_dot = 0; m_line = 0; m_odd = 0; m_vbl = 0;
        e_dc = 0; e_hb = 0; e_irq = 0;
    endtask

    task automatic model_step(input bit valid, input int cyc);
        int adv, divv, linelen, framelen, tall;
        e_dc = 0; e_hb = 0; e_irq = 0;
        if (!valid) return;
        m_acc = m_acc + cyc * 11;
        adv   = m_acc / 7;
        m_acc = m_acc % 7;
        if (hres_wide) divv = 7;
        else if (hres_sel == 2'd0) divv = 10;
        else if (hres_sel == 2'd1) divv = 8;
        else if (hres_sel == 2'd2) divv = 5;
        else divv = 4;
        linelen  = pal_mode ? 3406 : 3413;
        framelen = pal_mode ? 314 : 263;
        tall     = (vres_hi && interlace) ? 1 : 0;
        m_dot = m_dot + adv;
        e_dc  = adv / divv;
        if ((m_dot % divv) < (adv % divv)) e_dc = e_dc + 1;
        if (m_dot >= linelen) begin
            e_hb   = 1;
            m_dot  = m_dot - linelen;
            m_line = m_line + 1;
            if (interlace && !tall && m_line < 240) m_odd = 1 - m_odd;
            if (m_line >= framelen) begin
                m_line = 0;
                m_vbl  = 0;
                if (tall) m_odd = 1 - m_odd;
            end
            if (m_line == 240) begin
                m_vbl = 1;
                e_irq = 1;
            end
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int exp_odd;
        int bad;
        exp_odd = (m_odd != 0 && m_vbl == 0) ? 1 : 0;
        bad = 0;
        tests++;
        if (int'(dot_clocks) != e_dc) begin
            bad = 1; $display("FAIL %s/R5 dot_clocks act=%0d exp=%0d", phase, dot_clocks, e_dc);
        end
        if (int'(hblank) != e_hb) begin
            bad = 1; $display("FAIL %s/R6 hblank act=%0d exp=%0d", phase, hblank, e_hb);
        end
        if (int'(vblank) != m_vbl) begin
            bad = 1; $display("FAIL %s/R7 vblank act=%0d exp=%0d", phase, vblank, m_vbl);
        end
        if (int'(vblank_irq) != e_irq) begin
            bad = 1; $display("FAIL %s/R7 vblank_irq act=%0d exp=%0d", phase, vblank_irq, e_irq);
        end
        if (int'(odd_field) != exp_odd) begin
            bad = 1; $display("FAIL %s/R10 odd_field act=%0d exp=%0d", phase, odd_field, exp_odd);
        end
        if (bad) fails++;
        if (hblank) hb_count++;
        if (odd_field) odd_ever = 1;
        if (vblank_irq) begin
            if (irq_seen) frame_lines = hb_count;
            irq_seen++;
            hb_count = 0;
        end
    endtask

    // One cycle: compare at this negedge, drive, advance model, wait.
    task automatic cycle(input bit valid, input int cyc);
        compare_all();
        step_valid  = valid;
        step_cycles = CYC_W'(cyc);
        model_step(valid, cyc);
        @(negedge clk);
    endtask

    task automatic run_fixed(input int n, input int cyc);
        for (int i = 0; i < n; i++) cycle(1'b1, cyc);
    endtask

    task automatic run_rand(input int n, input int lo, input int hi);
        for (int i = 0; i < n; i++) cycle(($urandom_range(0, 3) != 0), $urandom_range(lo, hi));
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        step_valid = 1'b0;
        #1;
        check("R11", "dot_clocks in reset", int'(dot_clocks), 0);
        check("R11", "flags in reset", int'({hblank, vblank, vblank_irq, odd_field}), 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic frame_count(input int steps, input int exp_lines, input string tag);
        hb_count = 0; irq_seen = 0; frame_lines = -1;
        run_fixed(steps, 2000);
        check(tag, "lines between interrupts", frame_lines, exp_lines);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        apply_reset();

        // R1: three single-cycle updates at divider 4 give 0,0,1 dot clocks
        phase = "R1";
        hres_sel = 2'd3;
        cycle(1'b1, 1);
        cycle(1'b1, 1);
        cycle(1'b1, 1);
        compare_all();
        check("R1", "third small update dot_clocks", int'(dot_clocks), 1);
        run_rand(80, 0, 12);

        // R12: idle cycles, including a non-zero count without the strobe
        phase = "R12";
        cycle(1'b0, 1500);
        check("R12", "idle dot_clocks", int'(dot_clocks), 0);
        for (int i = 0; i < 20; i++) cycle(1'b0, $urandom_range(0, MAX_STEP));

        // R4: each divider setting
        phase = "R4";
        for (int s = 0; s < 5; s++) begin
            hres_wide = (s == 4);
            hres_sel  = 2'(s);
            run_rand(120, 0, MAX_STEP);
        end
        hres_wide = 1'b0; hres_sel = 2'd0;

        // R2/R3: full frames in both timings, counted through pulses
        phase = "R3";
        pal_mode = 1'b0;
        frame_count(620, 263, "R3");
        phase = "R2";
        pal_mode = 1'b1;
        frame_count(740, 314, "R2");

        // R8: 480 request without interlace keeps the field bit still
        phase = "R8";
        pal_mode = 1'b0; vres_hi = 1'b1; interlace = 1'b0; odd_ever = 0;
        run_fixed(600, MAX_STEP);
        check("R8", "field never set without interlace", odd_ever, 0);

        // R9: interlaced tall mode and interlaced short mode
        phase = "R9";
        interlace = 1'b1; vres_hi = 1'b1;
        run_fixed(900, MAX_STEP);
        vres_hi = 1'b0; pal_mode = 1'b1; odd_ever = 0;
        run_fixed(900, 1900);
        check("R9", "field toggles in short interlace", odd_ever, 1);

        // R10 / mixed: random modes
        phase = "R10";
        for (int k = 0; k < 12; k++) begin
            pal_mode  = $urandom_range(0, 1);
            interlace = $urandom_range(0, 1);
            vres_hi   = $urandom_range(0, 1);
            hres_wide = $urandom_range(0, 1);
            hres_sel  = 2'($urandom_range(0, 3));
            run_rand(150, 0, MAX_STEP);
        end

        // R11: reset in mid-run
        phase = "R11";
        apply_reset();
        compare_all();
        run_rand(50, 0, MAX_STEP);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule